// File: doc/BRIEF.md
# Dual-Channel Signalling Tone Gate

This block produces the on/off modulation for the 22 kHz signalling tone on several independent output channels. Two is the default. It runs from a clock at twenty times the tone frequency and divides that clock down to a square wave that is high for half of each period. Each channel has its own tone generator, so one channel's bursts never shift the phase of another channel's tone.

Each channel has four controls: a channel enable, a force bit, a passthrough bit and a modulation pin. The selection follows a fixed order. A disabled channel is silent. A set force bit gives a continuous tone. A set passthrough bit sends the modulation pin, already modulated outside the block, straight to the output. Otherwise the internal tone is sent out only while the modulation pin is high. In this last mode a host can key tone bursts directly on the pin. Each burst starts at the beginning of a high half-period, so every burst has the same leading edge.

The modulation pins are asynchronous to the clock and pass through a two-stage synchronizer. The output is registered. A pin change therefore reaches the output on the third clock edge after it is driven.

Top module: `tone_gate_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released with all controls low, every `tone_out` bit is 0.
- R2: While a channel's tone generator runs, its output is high for exactly 10 clock cycles and then low for exactly 10 clock cycles, a period of 20 cycles.
- R3: When `ch_enable`=1 and `tone_force`=1 on a channel, the channel outputs the continuous tone whatever level its `mod_pin` has.
- R4: When `ch_enable`=1, `tone_force`=0 and `ext_pass`=0, the channel outputs the internal tone while its synchronized `mod_pin` is 1, and 0 while it is 0.
- R5: When a channel's tone generator starts after being idle, its first 10 output cycles are high, so each gated burst begins at phase zero.
- R6: When `ch_enable`=1, `tone_force`=0 and `ext_pass`=1, `tone_out` equals `mod_pin` delayed by three clock edges (two synchronizer stages plus the output register).
- R7: When `ch_enable`=0, the channel's `tone_out` is 0 on the next clock edge and stays 0, whatever its other controls are.
- R8: The channels are independent: the controls and pin of one channel have no effect on the output of another.
- R9: When `tone_force`=1 and `ext_pass`=1 together, the force bit wins and the continuous tone is output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twenty times the tone frequency |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_enable | input | NUM_CH | Per-channel output enable; 0 silences the channel |
| tone_force | input | NUM_CH | Per-channel continuous-tone request |
| ext_pass | input | NUM_CH | Per-channel passthrough select for an externally modulated pin |
| mod_pin | input | NUM_CH | Per-channel asynchronous modulation pin |
| tone_out | output | NUM_CH | Per-channel registered tone modulation signal |

## Verification
A divider counter or phase bit that is wrong shows up as a high or low run on `tone_out` that is not 10 cycles long. It appears within one half-period, at most 10 cycles after the fault. A generator that does not restart leaves a burst that opens low or with a short first high run, and this is visible on the first output cycle after the three-edge pin latency. A wrong source selection or synchronizer depth gives an output that differs from the delayed pin or from the expected tone on the very next edge. The bench compares both channels to a behavioural model on every clock, so any such fault is reported in the cycle it first shows.

// File: rtl/tone_gate_pkg.sv
package tone_gate_pkg;

  typedef enum logic [1:0] {
    SRC_MUTE   = 2'd0,
    SRC_FORCED = 2'd1,
    SRC_PASS   = 2'd2,
    SRC_GATED  = 2'd3
  } tone_src_e;

  // Half of the division ratio: cycles per tone half-period.
  function automatic int half_cycles(input int ratio);
    return ratio / 2;
  endfunction

  // Fixed priority: disable, then force, then passthrough, then gated.
  function automatic tone_src_e pick_source(input logic en, input logic frc,
                                            input logic pas);
    if (!en)      return SRC_MUTE;
    else if (frc) return SRC_FORCED;
    else if (pas) return SRC_PASS;
    else          return SRC_GATED;
  endfunction

  // Whether the internal generator must run for this source.
  function automatic logic needs_tone(input tone_src_e src, input logic pin);
    case (src)
      SRC_FORCED: return 1'b1;
      SRC_GATED:  return pin;
      default:    return 1'b0;
    endcase
  endfunction

  // Output level for a source given generator phase and synchronized pin.
  function automatic logic tone_level(input tone_src_e src, input logic ph,
                                      input logic pin);
    case (src)
      SRC_FORCED: return ph;
      SRC_PASS:   return pin;
      SRC_GATED:  return pin & ph;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tgc_sync.sv
module tgc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tgc_divider.sv
module tgc_divider #(
  parameter int HALF = 10,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          phase,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  // Idle state is cnt 0 and phase high, so a fresh start opens a high half.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (!run) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tgc_channel.sv
module tgc_channel
  import tone_gate_pkg::*;
#(
  parameter int HALF = 10,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          frc,
  input  logic          pas,
  input  logic          pin_s,
  output logic          tone,
  output logic          req,
  output logic [CW-1:0] cnt
);
  tone_src_e src;
  logic      phase;

  assign src = pick_source(en, frc, pas);
  assign req = needs_tone(src, pin_s);

  tgc_divider #(.HALF(HALF), .CW(CW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (req),
    .phase (phase),
    .cnt   (cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tone <= 1'b0;
    else        tone <= tone_level(src, phase, pin_s);
  end
endmodule

// File: rtl/tone_gate_ctrl.sv
module tone_gate_ctrl
  import tone_gate_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int DIV_RATIO   = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [NUM_CH-1:0] tone_force,
  input  logic [NUM_CH-1:0] ext_pass,
  input  logic [NUM_CH-1:0] mod_pin,
  output logic [NUM_CH-1:0] tone_out
);
  localparam int HALF = half_cycles(DIV_RATIO);
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  // Named internal events for the checker.
  logic [NUM_CH-1:0]    pin_sync;
  logic [NUM_CH-1:0]    tone_req;
  logic [NUM_CH*CW-1:0] div_cnt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (mod_pin[c]),
      .dout  (pin_sync[c])
    );

    tgc_channel #(.HALF(HALF), .CW(CW)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ch_enable[c]),
      .frc   (tone_force[c]),
      .pas   (ext_pass[c]),
      .pin_s (pin_sync[c]),
      .tone  (tone_out[c]),
      .req   (tone_req[c]),
      .cnt   (div_cnt[c*CW +: CW])
    );
  end
endmodule

// File: rtl/tgc_checker.sv
module tgc_checker #(
  parameter int NUM_CH = 2,
  parameter int HALF   = 10,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_enable,
  input logic [NUM_CH-1:0] tone_force,
  input logic [NUM_CH-1:0] ext_pass,
  input logic [NUM_CH-1:0] tone_out,
  input logic [NUM_CH-1:0] pin_sync,
  input logic [NUM_CH-1:0] tone_req,
  input logic [NUM_CH*CW-1:0] div_cnt
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [CW-1:0] cnt_c;
    assign cnt_c = div_cnt[c*CW +: CW];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_c <= CW'(HALF - 1)); // R2

    AST_MUTE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_enable[c] |=> !tone_out[c]); // R7

    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_enable[c] && !tone_force[c] && ext_pass[c])
        |=> tone_out[c] == $past(pin_sync[c])); // R6

    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_enable[c] && !tone_force[c] && !ext_pass[c] && !pin_sync[c])
        |=> !tone_out[c]); // R4

    AST_BURST_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tone_req[c]) |=> tone_out[c]); // R5
  end
endmodule

bind tone_gate_ctrl tgc_checker #(.NUM_CH(NUM_CH), .HALF(HALF), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_enable  (ch_enable),
  .tone_force (tone_force),
  .ext_pass   (ext_pass),
  .tone_out   (tone_out),
  .pin_sync   (pin_sync),
  .tone_req   (tone_req),
  .div_cnt    (div_cnt)
);

// File: tb/sim_tone_gate_ctrl.sv
`timescale 1ns/1ps
module sim_tone_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int HALF_T = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ch_enable = '0, tone_force = '0, ext_pass = '0, mod_pin = '0;
  logic [NCH-1:0] tone_out;

  int checks = 0, fails = 0;
  bit done = 0;

  // Behavioural reference: pin delay line, run length of generator activity.
  bit pin_q [NCH][$];
  int run_len [NCH];
  bit exp_out [NCH];
  string tag [NCH];

  tone_gate_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .tone_force(tone_force),
    .ext_pass(ext_pass), .mod_pin(mod_pin), .tone_out(tone_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int c = 0; c < NCH; c++) begin
      pin_q[c] = '{0, 0};
      run_len[c] = 0;
      exp_out[c] = 0;
      tag[c] = "R1";
    end
  end

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        pin_q[c] = '{0, 0};
        run_len[c] = 0;
        exp_out[c] = 0;
        tag[c] = "R1";
      end else begin
        bit ps, req, hi;
        ps = pin_q[c].pop_front();
        pin_q[c].push_back(mod_pin[c]);
        req = ch_enable[c] && (tone_force[c] || (!ext_pass[c] && ps));
        hi = ((run_len[c] / HALF_T) % 2) == 0;
        if (!ch_enable[c])                  begin exp_out[c] = 0;       tag[c] = "R7"; end
        else if (tone_force[c] && ext_pass[c]) begin exp_out[c] = hi;   tag[c] = "R9"; end
        else if (tone_force[c])             begin exp_out[c] = hi;      tag[c] = "R3"; end
        else if (ext_pass[c])               begin exp_out[c] = ps;      tag[c] = "R6"; end
        else                                begin exp_out[c] = ps && hi; tag[c] = "R4"; end
        run_len[c] = req ? run_len[c] + 1 : 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done)
      for (int c = 0; c < NCH; c++) check(tag[c], tone_out[c], exp_out[c]);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Waits for a channel to go high, then returns its high and low run lengths.
  task automatic measure(input int c, output int hi_len, output int lo_len);
    int guard = 0;
    hi_len = 0; lo_len = 0;
    while (tone_out[c] !== 1'b1 && guard < 40) begin @(negedge clk); guard++; end
    while (tone_out[c] === 1'b1 && hi_len < 40) begin hi_len++; @(negedge clk); end
    while (tone_out[c] === 1'b0 && lo_len < 40) begin lo_len++; @(negedge clk); end
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int h, l;
    step(3);
    check("R1", tone_out, 0);
    rst_n = 1'b1;
    step(1);
    check("R1", tone_out, 0);
    ch_enable = 2'b11;
    step(5);

    // Gated burst on channel 0; channel 1 stays idle.
    mod_pin[0] = 1'b1;
    measure(0, h, l);
    check("R5", h, HALF_T);
    check("R8", tone_out[1], 0);
    step(30);
    mod_pin[0] = 1'b0;
    step(8);
    check("R4", tone_out[0], 0);

    // Forced tone on channel 1 with pin wiggling.
    tone_force[1] = 1'b1;
    measure(1, h, l);
    check("R2", h, HALF_T);
    check("R2", l, HALF_T);
    for (int i = 0; i < 12; i++) begin mod_pin[1] = ~mod_pin[1]; step(3); end
    check("R8", tone_out[0], 0);

    // Passthrough on channel 0.
    ext_pass[0] = 1'b1;
    for (int i = 0; i < 30; i++) begin mod_pin[0] = (i % 3 == 0) || (i % 7 == 1); step(1 + i % 4); end
    mod_pin[0] = 1'b1;
    step(4);
    check("R6", tone_out[0], 1);

    // Force and passthrough together on channel 0.
    tone_force[0] = 1'b1;
    mod_pin[0] = 1'b0;
    step(45);

    // Disable with force still set.
    ch_enable[0] = 1'b0;
    step(2);
    check("R7", tone_out[0], 0);
    step(25);
    check("R7", tone_out[0], 0);

    // Short bursts on channel 1, channel 0 back to gated.
    tone_force = '0; ext_pass = '0; ch_enable = 2'b11;
    for (int i = 0; i < 10; i++) begin
      mod_pin[1] = ~mod_pin[1];
      mod_pin[0] = (i % 4) < 2;
      step(7 + i);
    end
    mod_pin = '0;
    step(10);
    check("R4", tone_out, 0);

    // Second forced period measurement after re-enable.
    tone_force[0] = 1'b1;
    measure(0, h, l);
    check("R5", h, HALF_T);
    check("R2", l, HALF_T);
    step(5);
    finish_run();
  end
endmodule